// File: doc/BRIEF.md
# Shared Unit Ownership Lock Arbiter

This block decides which media engine owns each of two shared post-processing units. Decode engines and enhancement engines each raise a lock request toward the unit they are wired to. A free unit is granted to one requester and stays with it while that engine keeps requesting. The engine gives the unit up by dropping its request. For each engine the block reports a usage bit, which is set while the engine holds its unit.

Before an engine is reset, software raises a forced-lock control for it. The unit tied to that engine then freezes. A unit that is held stays with its owner even if the owner's request goes away. A unit that is free refuses every request. An acknowledge bit tells software that the freeze is in force. Software can then read the usage bit to see whether the unit must be reset along with the engine. Clearing the forced-lock control ends the freeze.

Top module: `sfc_lock_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no unit is held and every usage and acknowledge output is 0, whatever the request and force inputs are.
- R2: Decode engine i connects to unit i>>1, so decode engines 0 and 1 share unit 0 and decode engines 2 and 3 share unit 1. Enhancement engine i connects to unit i. Usage bit i of each output vector belongs to engine i of that class.
- R3: A decode engine whose bit in `dec_access` is 0 is never granted a unit. Its usage and acknowledge stay 0, and its force input does not freeze its unit.
- R4: A free unit that is not frozen is granted at the next clock edge to one of its requesting engines. The priority is decode engines before enhancement engines, and the lower instance number wins within a class.
- R5: An owner keeps its unit while its request is held. If the owner drops its request, the unit is free after the next edge. A waiting requester is granted one edge after that.
- R6: If any engine tied to a held unit asserts force, the unit stays with its current owner, even when the owner drops its request, until every such force is cleared.
- R7: If any engine tied to a free unit asserts force, every request to that unit is ignored until the force is cleared.
- R8: An engine's acknowledge rises at the second clock edge after its force input rises and stays high while force is held. It falls in the same cycle that force is cleared, with no clock edge in between.
- R9: Once all forces on a unit are cleared, normal arbitration resumes. Pending requests are granted, or a dropped owner is released, at the next edge.
- R10: At most one engine reports usage of a given unit at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_access | input | N_DEC | Per decode engine: 1 = may use its unit |
| dec_req | input | N_DEC | Lock request per decode engine |
| dec_force | input | N_DEC | Forced-lock control per decode engine |
| enh_req | input | N_ENH | Lock request per enhancement engine |
| enh_force | input | N_ENH | Forced-lock control per enhancement engine |
| dec_ack | output | N_DEC | Forced-lock acknowledge per decode engine |
| dec_usage | output | N_DEC | Decode engine currently holds its unit |
| enh_ack | output | N_ENH | Forced-lock acknowledge per enhancement engine |
| enh_usage | output | N_ENH | Enhancement engine currently holds its unit |

## Verification
Arbitration is tested with several kinds of request pattern:
- A lone requester on a unit.
- Several requesters at once on a unit. This separates the class priority from the instance priority.
- An owner that drops its request while another engine waits. This shows the idle cycle between release and the next grant.
- Requests from an engine that has no access. These show whether the access mask gates both grants and freezes.

Force is then applied in two cases. In the first it lands on a held unit, and it comes from either the owner or a sibling engine. In the second it lands on a free unit. These two cases separate holding a lock from refusing new requests. The acknowledge is sampled one and two edges after force rises, and again right after force is cleared, to pin down its rise and fall timing.

// File: rtl/sfc_lock_pkg.sv
// Package: shared constants and the engine-to-unit mapping for the lock arbiter.
// Assumes engines are numbered flat: decode engines first, then enhancement.
package sfc_lock_pkg;

    // Cycles from force rising to acknowledge rising.
    localparam int unsigned ACK_DELAY = 2;

    // Unit served by a flat engine index.
    function automatic int unsigned unit_of(int unsigned eng, int unsigned n_dec);
        if (eng < n_dec)
            return eng >> 1;
        else
            return eng - n_dec;
    endfunction

endpackage

// File: rtl/sfc_ack_timer.sv
// Module: per-engine acknowledge timer. Counts edges while force is held and
// enabled, then raises ack. Ack drops combinationally when force drops.
// Assumes force_in is synchronous to clk.
module sfc_ack_timer #(
    parameter int unsigned DELAY = 2,
    localparam int unsigned CW = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_in,
    input  logic enable,
    output logic ack
);

    logic          armed;
    logic [CW-1:0] cnt;

    // Force counts only for an engine allowed to use its unit.
    assign armed = force_in & enable;

    // Saturating count of edges seen with force held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!armed)
            cnt <= '0;
        else if (cnt != CW'(DELAY))
            cnt <= cnt + 1'b1;
    end

    // Ack once the delay has run out, cleared as soon as force goes.
    assign ack = armed & (cnt == CW'(DELAY));

    // R8: ack never rises without force held on the previous cycle.
    p_ack_after_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(armed));

    // R8: the edge right after force rises does not yet acknowledge.
    p_ack_not_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |=> !ack);

endmodule

// File: rtl/sfc_unit_owner.sv
// Module: ownership state of one shared unit. Grants the lowest-index eligible
// requester when free, releases when the owner drops its request, and freezes
// both states while frz is high. Assumes req_v already holds only engines
// eligible for this unit.
module sfc_unit_owner #(
    parameter int unsigned NT = 6,
    localparam int unsigned OW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] req_v,
    input  logic          frz,
    output logic          locked,
    output logic [OW-1:0] owner
);

    logic [OW-1:0] pick;
    logic          owner_req;

    // Fixed priority: the lowest flat index among the requesters wins.
    always_comb begin
        pick = '0;
        for (int e = NT - 1; e >= 0; e--) begin
            if (req_v[e])
                pick = OW'(e);
        end
    end

    // Whether the current owner still requests.
    always_comb begin
        owner_req = 1'b0;
        for (int e = 0; e < NT; e++) begin
            if (owner == OW'(e) && req_v[e])
                owner_req = 1'b1;
        end
    end

    // Ownership update: hold everything while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (!frz) begin
            if (locked) begin
                if (!owner_req)
                    locked <= 1'b0;
            end else if (|req_v) begin
                locked <= 1'b1;
                owner  <= pick;
            end
        end
    end

    // R6 / R7: a freeze keeps the lock state unchanged over the next edge.
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(locked));

    // R6: a held unit keeps its owner through a freeze.
    p_freeze_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && locked) |=> $stable(owner));

    // R4: a free, unfrozen unit with a requester is held after the edge.
    p_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && !locked && (|req_v)) |=> locked);

    // R5: an unfrozen owner that stops requesting is released.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && locked && !owner_req) |=> !locked);

endmodule

// File: rtl/sfc_lock_arbiter.sv
// Module: top of the shared unit lock arbiter. Flattens the decode and
// enhancement engines into one index space, works out which engines may reach
// each unit, builds one owner per unit and one acknowledge timer per engine,
// and reports usage. Assumes N_DEC <= 2*N_UNIT and N_ENH <= N_UNIT.
module sfc_lock_arbiter
    import sfc_lock_pkg::*;
#(
    parameter int unsigned N_DEC  = 4,
    parameter int unsigned N_ENH  = 2,
    parameter int unsigned N_UNIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEC-1:0] dec_access,
    input  logic [N_DEC-1:0] dec_req,
    input  logic [N_DEC-1:0] dec_force,
    input  logic [N_ENH-1:0] enh_req,
    input  logic [N_ENH-1:0] enh_force,
    output logic [N_DEC-1:0] dec_ack,
    output logic [N_DEC-1:0] dec_usage,
    output logic [N_ENH-1:0] enh_ack,
    output logic [N_ENH-1:0] enh_usage
);

    localparam int unsigned NT = N_DEC + N_ENH;
    localparam int unsigned OW = (NT > 1) ? $clog2(NT) : 1;

    logic [NT-1:0]              req_all;
    logic [NT-1:0]              frc_all;
    logic [NT-1:0]              acc_all;
    logic [NT-1:0]              ack_all;
    logic [NT-1:0]              use_all;
    logic [N_UNIT-1:0][NT-1:0]  elig;
    logic [N_UNIT-1:0]          frz;
    logic [N_UNIT-1:0]          unit_locked;
    logic [N_UNIT-1:0][OW-1:0]  unit_owner;

    // Flat engine vectors: decode in the low bits, enhancement above.
    assign req_all = {enh_req, dec_req};
    assign frc_all = {enh_force, dec_force};
    assign acc_all = {{N_ENH{1'b1}}, dec_access};

    // Which engines may reach each unit (R2 mapping, R3 access gating).
    always_comb begin
        for (int u = 0; u < N_UNIT; u++) begin
            for (int e = 0; e < NT; e++) begin
                elig[u][e] = acc_all[e] && (unit_of(e, N_DEC) == u);
            end
        end
    end

    genvar gu, ge;
    generate
        for (gu = 0; gu < N_UNIT; gu++) begin : g_unit
            // A unit freezes when any eligible engine on it forces.
            assign frz[gu] = |(frc_all & elig[gu]);

            sfc_unit_owner #(.NT(NT)) owner_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_v  (req_all & elig[gu]),
                .frz    (frz[gu]),
                .locked (unit_locked[gu]),
                .owner  (unit_owner[gu])
            );

            // R10: only one engine reports usage of this unit.
            p_one_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(use_all & elig[gu]));
        end

        for (ge = 0; ge < NT; ge++) begin : g_eng
            sfc_ack_timer #(.DELAY(ACK_DELAY)) timer_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .force_in (frc_all[ge]),
                .enable   (acc_all[ge]),
                .ack      (ack_all[ge])
            );
        end
    endgenerate

    // Usage: the engine is eligible and owns a held unit.
    always_comb begin
        for (int e = 0; e < NT; e++) begin
            use_all[e] = 1'b0;
            for (int u = 0; u < N_UNIT; u++) begin
                if (elig[u][e] && unit_locked[u] && unit_owner[u] == OW'(e))
                    use_all[e] = 1'b1;
            end
        end
    end

    // Split the flat vectors back out per engine class.
    assign dec_usage = use_all[N_DEC-1:0];
    assign enh_usage = use_all[NT-1:N_DEC];
    assign dec_ack   = ack_all[N_DEC-1:0];
    assign enh_ack   = ack_all[NT-1:N_DEC];

    // R3: an engine without access never shows usage.
    p_no_access_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_usage & ~dec_access) == '0);

endmodule

// File: tb/sfc_lock_arbiter_tb.sv
// Bench: a table walk of request and force patterns, then directed tests for
// reset, acknowledge timing, access gating and a freeze raised by a sibling.
module sfc_lock_arbiter_tb_top;

    localparam int PERIOD = 10;
    localparam int ND = 4;
    localparam int NE = 2;
    localparam int NROW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] dec_access = 4'b1011;
    logic [ND-1:0] dec_req = '0;
    logic [ND-1:0] dec_force = '0;
    logic [NE-1:0] enh_req = '0;
    logic [NE-1:0] enh_force = '0;
    logic [ND-1:0] dec_ack;
    logic [ND-1:0] dec_usage;
    logic [NE-1:0] enh_ack;
    logic [NE-1:0] enh_usage;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sfc_lock_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .dec_access(dec_access),
        .dec_req(dec_req), .dec_force(dec_force),
        .enh_req(enh_req), .enh_force(enh_force),
        .dec_ack(dec_ack), .dec_usage(dec_usage),
        .enh_ack(enh_ack), .enh_usage(enh_usage)
    );

    // Row fields: dec_req, enh_req, dec_force, enh_force, expected dec_usage,
    // expected enh_usage. Access is 1011: decode 2 may not use unit 1.
    localparam logic [17:0] VEC [0:NROW-1] = '{
        {4'b0001, 2'b00, 4'b0000, 2'b00, 4'b0001, 2'b00}, // R4 lone grant
        {4'b0011, 2'b01, 4'b0000, 2'b00, 4'b0001, 2'b00}, // R5 owner holds
        {4'b0010, 2'b01, 4'b0000, 2'b00, 4'b0000, 2'b00}, // R5 release
        {4'b0010, 2'b01, 4'b0000, 2'b00, 4'b0010, 2'b00}, // R4 decode before enh
        {4'b0100, 2'b10, 4'b0000, 2'b00, 4'b0000, 2'b10}, // R3 no access, R2 enh1->u1
        {4'b1100, 2'b11, 4'b0000, 2'b00, 4'b0000, 2'b11}, // R2 enh0->u0
        {4'b1000, 2'b01, 4'b0000, 2'b00, 4'b0000, 2'b01}, // R5 enh1 release
        {4'b1000, 2'b01, 4'b0000, 2'b00, 4'b1000, 2'b01}, // R2 dec3->u1
        {4'b1000, 2'b00, 4'b0000, 2'b01, 4'b1000, 2'b01}, // R6 owner forced, drops req
        {4'b0001, 2'b00, 4'b0000, 2'b01, 4'b0000, 2'b01}, // R6 held, R7-like refusal
        {4'b0001, 2'b00, 4'b0000, 2'b00, 4'b0000, 2'b00}, // R9 release on clear
        {4'b0001, 2'b00, 4'b0000, 2'b00, 4'b0001, 2'b00}, // R9 grant resumes
        {4'b0000, 2'b10, 4'b1000, 2'b00, 4'b0000, 2'b00}, // R7 free unit refuses
        {4'b1000, 2'b10, 4'b1000, 2'b00, 4'b0000, 2'b00}, // R7 still refuses
        {4'b1000, 2'b10, 4'b0000, 2'b00, 4'b1000, 2'b00}, // R9 and R4 priority
        {4'b0000, 2'b10, 4'b0100, 2'b00, 4'b0000, 2'b00}, // R3 force without access
        {4'b0000, 2'b10, 4'b0100, 2'b00, 4'b0000, 2'b10}  // R3 no freeze, enh1 granted
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset with every request and force high.
        dec_req = '1; enh_req = '1; dec_force = '1; enh_force = '1;
        step(); step();
        chk("R1 reset usage", {2'b0, enh_usage, dec_usage}, 8'h00);
        chk("R1 reset ack", {2'b0, enh_ack, dec_ack}, 8'h00);
        dec_req = '0; enh_req = '0; dec_force = '0; enh_force = '0;
        rst_n = 1'b1;
        step();
        chk("R1 first cycle out of reset", {2'b0, enh_usage, dec_usage}, 8'h00);

        // Table walk: R2 R4 R5 R6 R7 R9 R3.
        for (int r = 0; r < NROW; r++) begin
            {dec_req, enh_req, dec_force, enh_force} = VEC[r][17:6];
            step();
            chk($sformatf("table row %0d usage (R2/R3/R4/R5/R6/R7/R9)", r),
                {2'b0, enh_usage, dec_usage}, {2'b0, VEC[r][1:0], VEC[r][5:2]});
        end

        // Reset in mid-operation clears ownership (R1).
        rst_n = 1'b0;
        step();
        chk("R1 reset while held", {2'b0, enh_usage, dec_usage}, 8'h00);
        dec_req = '0; enh_req = '0; dec_force = '0; enh_force = '0;
        rst_n = 1'b1;
        step();

        // R8: acknowledge timing on decode 0.
        dec_force = 4'b0001;
        step();
        chk("R8 ack low after one edge", {4'b0, dec_ack}, 8'h00);
        step();
        chk("R8 ack high after two edges", {4'b0, dec_ack}, 8'h01);
        step();
        chk("R8 ack stays while force held", {4'b0, dec_ack}, 8'h01);
        dec_force = '0;
        #1;
        chk("R8 ack falls with force", {4'b0, dec_ack}, 8'h00);

        // R8: enhancement engine 1.
        enh_force = 2'b10;
        step(); step();
        chk("R8 enh ack after two edges", {6'b0, enh_ack}, 8'h02);
        enh_force = '0;
        #1;
        chk("R8 enh ack falls", {6'b0, enh_ack}, 8'h00);

        // R3: no-access engine never acknowledges and is never granted.
        dec_force = 4'b0100;
        dec_req = 4'b0100;
        step(); step(); step();
        chk("R3 no ack without access", {4'b0, dec_ack}, 8'h00);
        chk("R3 no usage without access", {4'b0, dec_usage}, 8'h00);
        dec_force = '0; dec_req = '0;
        step();

        // R6: a sibling's force holds decode 1's lock after it drops its request.
        dec_req = 4'b0010;
        step();
        chk("R4 dec1 granted", {4'b0, dec_usage}, 8'h02);
        dec_force = 4'b0001;
        dec_req = 4'b0000;
        step(); step();
        chk("R6 sibling force keeps owner", {4'b0, dec_usage}, 8'h02);
        chk("R8 sibling ack", {4'b0, dec_ack}, 8'h01);
        dec_force = '0;
        step();
        chk("R9 release after clear", {4'b0, dec_usage}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule